// File: doc/BRIEF.md
# Transmit Queue Status Interrupt

This block watches the transmit queue of a link node. It keeps the number of entries held in the queue and decides whether each host write is accepted or refused. It raises one local status interrupt for two causes: a host write that arrives while the queue holds more than half its capacity, and a corrupt transfer reported by the receive checker. The queue storage, the link serializer and the interrupt controller sit outside the block. The block drives the store strobe of the queue and takes a drain strobe back from the link side.

A host write gets an acknowledge in the same cycle, or a bus error when the queue is already full. A refused write is not stored, so no data is lost without notice. Each interrupt cause has a sticky status bit. A pending bit, which drives the interrupt line, sits above the two cause bits. Software clears these bits by writing ones. The corrupt-transfer cause has its own mask. This lets a node running redundant transfers suppress that cause while the occupancy cause keeps working.

Top module: `txq_stat_irq`

## Requirements
- R1: After reset the occupancy is 0, the half and full flags are low, and the pending bit, both cause bits and the interrupt line are low.
- R2: A host write to a non-full queue is acknowledged in the same cycle, asserts the store strobe, and raises the occupancy by one at the next clock edge. A drain strobe lowers the occupancy by one. A write and a drain in the same cycle leave the occupancy unchanged. A drain while the occupancy is 0 is ignored.
- R3: The half flag is high exactly when the occupancy exceeds DEPTH/2 (8 with the default depth of 16). The full flag is high exactly when the occupancy equals DEPTH.
- R4: A host write while the queue is full gets a bus error in the same cycle instead of an acknowledge. It does not assert the store strobe and leaves the occupancy unchanged.
- R5: With the interrupt enabled, a host write (accepted or refused) seen while the occupancy before the write exceeds DEPTH/2 sets the pending bit and the occupancy cause bit at the next edge. A write at an occupancy of DEPTH/2 or less sets neither.
- R6: With the interrupt enabled and the error mask low, a corrupt-transfer strobe sets the pending bit and the error cause bit at the next edge.
- R7: With the error mask high, a corrupt-transfer strobe sets nothing, while the occupancy cause still fires as in R5.
- R8: With the interrupt enable low, neither cause sets any bit.
- R9: The clear vector is write-1-to-clear. Bit 0 clears the pending bit, bit 1 clears the occupancy cause bit and bit 2 clears the error cause bit, each at the next edge. When a bit is set and cleared in the same cycle, the set wins.
- R10: The interrupt output equals the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write attempt into the transmit queue |
| link_drain | input | 1 | Link side removed one entry |
| xfer_bad | input | 1 | Corrupt transfer detected |
| irq_enable | input | 1 | Enables both interrupt causes |
| bad_mask | input | 1 | Suppresses the corrupt-transfer cause |
| clr_w1c | input | 3 | Write-1-to-clear: bit0 pending, bit1 occupancy cause, bit2 error cause |
| host_ack | output | 1 | Write accepted (combinational) |
| host_berr | output | 1 | Write refused, queue full (combinational) |
| q_store | output | 1 | Store strobe to the queue |
| occupancy | output | 5 | Entries held |
| half_flag | output | 1 | Occupancy above half |
| full_flag | output | 1 | Queue full |
| irq_pend | output | 1 | Pending bit |
| cause_occ | output | 1 | Occupancy cause bit |
| cause_bad | output | 1 | Error cause bit |
| irq | output | 1 | Local status interrupt line |

## Verification
The acknowledge, the bus error and the store strobe follow the current inputs and state combinationally. The bench samples them one nanosecond after it drives inputs on the falling edge. Occupancy, the flags, the pending bit and the cause bits change one rising edge after their stimulus. The driver queues the expected value of each of these for that edge, and the monitor compares them one nanosecond after the edge. The boundary cases are writes at an occupancy of exactly half and at full, a drain at empty, a set and a clear in the same cycle, and a masked error.

// File: rtl/txq_stat_pkg.sv
package txq_stat_pkg;
    typedef struct packed {
        logic pend;
        logic occ;
        logic bad;
    } irq_state_t;

    localparam int CLR_PEND = 0;
    localparam int CLR_OCC  = 1;
    localparam int CLR_BAD  = 2;
endpackage

// File: rtl/txq_occ_track.sv
module txq_occ_track #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          drain,
    output logic [CW-1:0] count,
    output logic          half,
    output logic          full
);
    localparam logic [CW-1:0] TOP  = CW'(DEPTH);
    localparam logic [CW-1:0] MID  = CW'(DEPTH / 2);

    logic [CW-1:0] count_d, count_q;
    logic          drain_eff;

    always_comb begin
        drain_eff = drain && (count_q != '0);
        count_d   = count_q;
        if (push && !drain_eff)
            count_d = count_q + 1'b1;
        else if (drain_eff && !push)
            count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
    assign half  = count_q > MID;
    assign full  = count_q == TOP;

    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= TOP);
    a_r2_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !drain) |=> count_q == $past(count_q) + 1'b1);
    a_r2_empty_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0 && drain && !push) |=> count_q == '0);
endmodule

// File: rtl/txq_irq_cause.sv
module txq_irq_cause
    import txq_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_occ,
    input  logic       fire_bad,
    input  logic [2:0] clr,
    output irq_state_t st
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (fire_occ || fire_bad) || (st_q.pend && !clr[CLR_PEND]);
        st_d.occ  = fire_occ || (st_q.occ && !clr[CLR_OCC]);
        st_d.bad  = fire_bad || (st_q.bad && !clr[CLR_BAD]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    a_r6_bad_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fire_bad |=> (st_q.pend && st_q.bad));
    a_r9_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[CLR_PEND] && !fire_occ && !fire_bad) |=> !st_q.pend);
    a_r5_cause_implies_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.occ) |-> st_q.pend);
endmodule

// File: rtl/txq_stat_irq.sv
module txq_stat_irq
    import txq_stat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          link_drain,
    input  logic          xfer_bad,
    input  logic          irq_enable,
    input  logic          bad_mask,
    input  logic [2:0]    clr_w1c,
    output logic          host_ack,
    output logic          host_berr,
    output logic          q_store,
    output logic [CW-1:0] occupancy,
    output logic          half_flag,
    output logic          full_flag,
    output logic          irq_pend,
    output logic          cause_occ,
    output logic          cause_bad,
    output logic          irq
);
    logic       fire_occ, fire_bad;
    irq_state_t st;

    assign host_berr = host_wr && full_flag;
    assign host_ack  = host_wr && !full_flag;
    assign q_store   = host_ack;
    assign fire_occ  = irq_enable && host_wr && half_flag;
    assign fire_bad  = irq_enable && xfer_bad && !bad_mask;

    txq_occ_track #(.DEPTH(DEPTH)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_store),
        .drain (link_drain),
        .count (occupancy),
        .half  (half_flag),
        .full  (full_flag)
    );

    txq_irq_cause u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_occ (fire_occ),
        .fire_bad (fire_bad),
        .clr      (clr_w1c),
        .st       (st)
    );

    assign irq_pend  = st.pend;
    assign cause_occ = st.occ;
    assign cause_bad = st.bad;
    assign irq       = st.pend;

    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ack && host_berr));
    a_r4_full_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && full_flag) |=> occupancy == $past(occupancy) - CW'($past(link_drain)));
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_enable && !irq_pend && clr_w1c[0]) |=> !irq_pend);
    a_r3_full_is_half: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag |-> half_flag);
endmodule

// File: tb/tb_txq_stat_irq.sv
`timescale 1ns/1ps
module tb_txq_stat_irq;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0;
    logic host_wr = 0, link_drain = 0, xfer_bad = 0, irq_enable = 0, bad_mask = 0;
    logic [2:0] clr_w1c = '0;
    logic host_ack, host_berr, q_store, half_flag, full_flag;
    logic irq_pend, cause_occ, cause_bad, irq;
    logic [CW-1:0] occupancy;

    always #4 clk = ~clk;

    txq_stat_irq #(.DEPTH(DEPTH)) dut (.*);

    typedef struct {
        int cnt; bit half; bit full; bit pend; bit co; bit cb; string tag;
    } exp_t;
    exp_t q[$];

    int tests = 0, fails = 0;
    int m_cnt = 0; bit m_pend = 0, m_co = 0, m_cb = 0;
    bit done = 0;

    task automatic chk(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit wr, bit dr, bit bad, bit [2:0] clr, string tag);
        bit full, push, drv, fo, fb;
        exp_t e;
        @(negedge clk);
        host_wr = wr; link_drain = dr; xfer_bad = bad; clr_w1c = clr;
        #1;
        full = (m_cnt == DEPTH);
        push = wr && !full;
        chk(tag, "ack", host_ack, push);
        chk(tag, "berr", host_berr, wr && full);
        chk(tag, "store", q_store, push);
        drv  = dr && m_cnt > 0;
        fo   = irq_enable && wr && (m_cnt > DEPTH / 2);
        fb   = irq_enable && bad && !bad_mask;
        m_cnt = m_cnt + int'(push) - int'(drv);
        m_pend = fo || fb || (m_pend && !clr[0]);
        m_co   = fo || (m_co && !clr[1]);
        m_cb   = fb || (m_cb && !clr[2]);
        e.cnt = m_cnt; e.half = m_cnt > DEPTH / 2; e.full = m_cnt == DEPTH;
        e.pend = m_pend; e.co = m_co; e.cb = m_cb; e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "occupancy", int'(occupancy), e.cnt);
            chk({e.tag, "/R3"}, "half", half_flag, e.half);
            chk({e.tag, "/R3"}, "full", full_flag, e.full);
            chk(e.tag, "pend", irq_pend, e.pend);
            chk(e.tag, "cause_occ", cause_occ, e.co);
            chk(e.tag, "cause_bad", cause_bad, e.cb);
            chk("R10", "irq", irq, irq_pend);
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "occupancy", int'(occupancy), 0);
        chk("R1", "flags", {half_flag, full_flag}, 0);
        chk("R1", "irq bits", {irq_pend, cause_occ, cause_bad, irq}, 0);
        @(negedge clk); rst_n = 1;
        irq_enable = 1; bad_mask = 0;

        repeat (3) step(1, 0, 0, 3'b000, "R2");
        step(0, 1, 0, 3'b000, "R2");
        step(1, 1, 0, 3'b000, "R2");
        repeat (3) step(0, 1, 0, 3'b000, "R2");
        repeat (9) step(1, 0, 0, 3'b000, "R5");
        step(1, 0, 0, 3'b000, "R5");
        step(0, 0, 0, 3'b111, "R9");
        repeat (6) step(1, 0, 0, 3'b111, "R3");
        step(0, 0, 0, 3'b111, "R9");
        step(1, 0, 0, 3'b000, "R4");
        step(1, 0, 0, 3'b111, "R4");
        step(0, 0, 0, 3'b111, "R9");
        step(0, 0, 1, 3'b000, "R6");
        step(0, 0, 0, 3'b100, "R9");
        step(0, 0, 0, 3'b001, "R9");
        bad_mask = 1;
        step(0, 0, 1, 3'b000, "R7");
        step(1, 1, 0, 3'b000, "R7");
        step(1, 1, 0, 3'b011, "R9");
        step(0, 0, 0, 3'b111, "R9");
        bad_mask = 0; irq_enable = 0;
        step(1, 1, 1, 3'b000, "R8");
        step(0, 0, 1, 3'b000, "R8");
        repeat (16) step(0, 1, 0, 3'b000, "R2");
        step(0, 0, 0, 3'b000, "R2");
        repeat (3) @(posedge clk);
        #2;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule